// File: doc/BRIEF.md
# Synchronous Serial Port Controller

The block is the register-level front end of a synchronous serial port. A small register bus gives software access to two control registers, a data port, a status register, a clock prescale register and the interrupt registers. Words written to the data port are cut to the programmed frame size and queued in a transmit FIFO. A transfer engine drains that FIFO. In loopback mode it copies each word straight into the receive FIFO. Otherwise it hands the word to an external shifter through a request/acknowledge exchange and stores the returned word. Software collects received words by reading the data port.

Status flags and the raw interrupt bits are derived directly from the two FIFO occupancies, with half-depth thresholds. One level interrupt output reports the raw bits that survive the interrupt mask. The engine stops whenever the receive FIFO is full and resumes as soon as software makes room. Pin-level serial timing, DMA and peripheral (slave) mode lie outside this block.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset, status (0x0C) reads 0x03, raw interrupt status (0x18) reads 0x08, masked status (0x1C) reads 0, `irq_o` is low, and a data read returns 0.
- R2: The status bits are bit 0 transmit FIFO empty, bit 1 transmit FIFO not full, bit 2 receive FIFO not empty, bit 3 receive FIFO full, bit 4 busy. Busy is set whenever the transmit FIFO holds a word. Both FIFOs hold 8 words.
- R3: A write to the data port (0x08) while the transmit FIFO holds 8 words is dropped, and the FIFO contents and flags are unchanged.
- R4: A data read while the receive FIFO is empty returns 0 and changes no FIFO state.
- R5: The frame mask is (1 << (ctrl0[3:0] + 1)) - 1, where ctrl0 is at 0x00. It is applied when a word enters the transmit FIFO, and again when a word enters the receive FIFO.
- R6: ctrl1 (0x04) bit 1 enables the port and bit 0 selects loopback. With both bits set, queued words reach the receive FIFO in order, with no exchange request.
- R7: With the port enabled and loopback off, each word is presented on `xchg_wdata_o` with `xchg_req_o` held high and stable until `xchg_ack_i`. Only one exchange is outstanding at a time. The returned word, masked, enters the receive FIFO.
- R8: The engine moves no word while the receive FIFO is full. Each read that frees an entry lets one more word through.
- R9: With the port disabled, queued words stay in the transmit FIFO.
- R10: Raw interrupt bit 2 is set while the receive FIFO holds 4 or more words. Raw bit 3 is set while the transmit FIFO holds 4 or fewer. Raw bits 0 and 1 always read 0, and a write to the clear register (0x20) changes nothing visible.
- R11: Mask register 0x14 holds 4 bits. `irq_o` is high exactly when raw status AND mask is nonzero, and 0x1C reads that AND.
- R12: ctrl0 reads back 16 bits and ctrl1 reads back its low 4 bits. Prescale (0x10) keeps its low 8 bits. DMA control (0x24) reads 0 whatever is written. Unmapped offsets read 0 and ignore writes.
- R13: Offsets 0xFE0 to 0xFFC read, one byte per word, 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register byte offset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (pops the receive FIFO at the data offset) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the cycle of `rd_en_i` |
| xchg_req_o | output | 1 | Exchange request to the external shifter |
| xchg_wdata_o | output | 16 | Word to shift out |
| xchg_ack_i | input | 1 | Exchange complete |
| xchg_rdata_i | input | 16 | Word shifted in, sampled with `xchg_ack_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
The frame-size field is swept over all 16 values in loopback with an all-ones style word. This separates the transmit-side cut from the receive-side cut, because the field is also changed between queueing and transfer. The transmit FIFO is filled one word at a time from empty to beyond full, and the receive FIFO is drained from full to beyond empty. Every occupancy is compared against status and raw interrupt values computed arithmetically, which exposes off-by-one errors at the half and full thresholds and at the dropped write. A run with the receive FIFO full and words still queued shows the stall and the in-order release. A handshake run with a delayed responder that inverts a bit pattern shows that the returned word, not the sent one, is stored, and that one request is made per word.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam logic [11:0] OFF_CTRL0  = 12'h000;
  localparam logic [11:0] OFF_CTRL1  = 12'h004;
  localparam logic [11:0] OFF_DATA   = 12'h008;
  localparam logic [11:0] OFF_STAT   = 12'h00C;
  localparam logic [11:0] OFF_PRESC  = 12'h010;
  localparam logic [11:0] OFF_IMASK  = 12'h014;
  localparam logic [11:0] OFF_IRAW   = 12'h018;
  localparam logic [11:0] OFF_IMSK   = 12'h01C;
  localparam logic [11:0] OFF_ICLR   = 12'h020;
  localparam logic [11:0] OFF_DMA    = 12'h024;

  // ctrl1 bit positions
  localparam int C1_LOOP = 0;
  localparam int C1_EN   = 1;

  typedef struct packed {
    logic busy;
    logic rx_full;
    logic rx_nempty;
    logic tx_nfull;
    logic tx_empty;
  } port_stat_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h22;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/spi_port_fifo.sv
module spi_port_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] cnt_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    nxt = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign push_ok = push_i && (cnt_q != CW'(DEPTH));
  assign pop_ok  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o = mem_q[rd_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          loop_i,
  input  logic          tx_avail_i,
  input  logic          rx_room_i,
  input  logic [DW-1:0] tx_head_i,
  input  logic [DW-1:0] mask_i,
  output logic          tx_pop_o,
  output logic          rx_push_o,
  output logic [DW-1:0] rx_data_o,
  output logic          req_o,
  output logic [DW-1:0] req_data_o,
  input  logic          ack_i,
  input  logic [DW-1:0] ack_data_i
);
  logic pend_q;
  logic can_move, loop_mv, issue, done;

  assign can_move = en_i && tx_avail_i && rx_room_i && !pend_q;
  assign loop_mv  = can_move && loop_i;
  assign issue    = can_move && !loop_i;
  assign done     = pend_q && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (done)  pend_q <= 1'b0;
    else if (issue) pend_q <= 1'b1;
  end

  assign tx_pop_o   = loop_mv || done;
  assign rx_push_o  = loop_mv || done;
  assign rx_data_o  = (loop_mv ? tx_head_i : ack_data_i) & mask_i;
  assign req_o      = pend_q;
  assign req_data_o = pend_q ? tx_head_i : '0;
endmodule

// File: rtl/spi_port_flags.sv
module spi_port_flags
  import spi_port_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] tx_cnt_i,
  input  logic [CW-1:0] rx_cnt_i,
  output port_stat_t    stat_o,
  output logic [3:0]    raw_o
);
  localparam int HALF = DEPTH / 2;

  always_comb begin
    stat_o.tx_empty  = (tx_cnt_i == '0);
    stat_o.tx_nfull  = (tx_cnt_i != CW'(DEPTH));
    stat_o.rx_nempty = (rx_cnt_i != '0);
    stat_o.rx_full   = (rx_cnt_i == CW'(DEPTH));
    stat_o.busy      = (tx_cnt_i != '0);
    // bits 0/1 (overrun, timeout) are never raised
    raw_o = {tx_cnt_i <= CW'(HALF), rx_cnt_i >= CW'(HALF), 2'b00};
  end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          xchg_req_o,
  output logic [DW-1:0] xchg_wdata_o,
  input  logic          xchg_ack_i,
  input  logic [DW-1:0] xchg_rdata_i,
  output logic          irq_o
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int FS_W = $clog2(DW);

  logic [DW-1:0] ctrl0_q;
  logic [3:0]    ctrl1_q;
  logic [7:0]    presc_q;
  logic [3:0]    imask_q;

  logic [DW-1:0] mask;
  logic [DW:0]   mask_ext;
  logic [FS_W:0] shamt;

  logic          tx_push, tx_pop, rx_push, rx_pop;
  logic [DW-1:0] tx_head, rx_head, rx_in;
  logic [CW-1:0] tx_cnt, rx_cnt;
  port_stat_t    stat;
  logic [3:0]    raw;
  logic          wr_data, rd_data;

  assign shamt    = {1'b0, ctrl0_q[FS_W-1:0]} + (FS_W + 1)'(1);
  assign mask_ext = ((DW + 1)'(1) << shamt) - (DW + 1)'(1);
  assign mask     = mask_ext[DW-1:0];

  assign wr_data = wr_en_i && (addr_i == AW'(OFF_DATA));
  assign rd_data = rd_en_i && (addr_i == AW'(OFF_DATA));
  assign tx_push = wr_data && stat.tx_nfull;
  assign rx_pop  = rd_data && stat.rx_nempty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
      presc_q <= '0;
      imask_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        AW'(OFF_CTRL0): ctrl0_q <= wdata_i;
        AW'(OFF_CTRL1): ctrl1_q <= wdata_i[3:0];
        AW'(OFF_PRESC): presc_q <= wdata_i[7:0];
        AW'(OFF_IMASK): imask_q <= wdata_i[3:0];
        default: ;
      endcase
    end
  end

  spi_port_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .push_data_i(wdata_i & mask),
    .pop_i(tx_pop), .head_o(tx_head), .cnt_o(tx_cnt)
  );

  spi_port_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .push_data_i(rx_in),
    .pop_i(rx_pop), .head_o(rx_head), .cnt_o(rx_cnt)
  );

  spi_port_engine #(.DW(DW)) u_engine (
    .clk_i, .rst_ni,
    .en_i(ctrl1_q[C1_EN]), .loop_i(ctrl1_q[C1_LOOP]),
    .tx_avail_i(!stat.tx_empty), .rx_room_i(!stat.rx_full),
    .tx_head_i(tx_head), .mask_i(mask),
    .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_data_o(rx_in),
    .req_o(xchg_req_o), .req_data_o(xchg_wdata_o),
    .ack_i(xchg_ack_i), .ack_data_i(xchg_rdata_i)
  );

  spi_port_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .stat_o(stat), .raw_o(raw)
  );

  assign irq_o = |(raw & imask_q);

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i[AW-1:5] == '1) begin
        rdata_o = DW'(id_byte(addr_i[4:2]));
      end else begin
        case (addr_i)
          AW'(OFF_CTRL0): rdata_o = ctrl0_q;
          AW'(OFF_CTRL1): rdata_o = DW'(ctrl1_q);
          AW'(OFF_DATA):  rdata_o = stat.rx_nempty ? rx_head : '0;
          AW'(OFF_STAT):  rdata_o = DW'(stat);
          AW'(OFF_PRESC): rdata_o = DW'(presc_q);
          AW'(OFF_IMASK): rdata_o = DW'(imask_q);
          AW'(OFF_IRAW):  rdata_o = DW'(raw);
          AW'(OFF_IMSK):  rdata_o = DW'(raw & imask_q);
          default:        rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_port_ctrl_chk.sv
module spi_port_ctrl_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req,
  input logic          ack,
  input logic [DW-1:0] wdata,
  input logic          en,
  input logic          loop,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_pop,
  input logic          wr_data,
  input logic [3:0]    imask,
  input logic          irq
);
  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && !ack |=> req && $stable(wdata));

  assert_req_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req) |-> $past(en && !loop));

  assert_tx_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= CW'(DEPTH));

  assert_rx_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= CW'(DEPTH));

  assert_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data && tx_cnt == CW'(DEPTH) && !tx_pop |=> tx_cnt == CW'(DEPTH));

  assert_no_move_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en && !req |-> !tx_pop);

  assert_irq_masked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imask == '0 |-> !irq);
endmodule

bind spi_port_ctrl spi_port_ctrl_chk #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req(xchg_req_o), .ack(xchg_ack_i), .wdata(xchg_wdata_o),
  .en(ctrl1_q[1]), .loop(ctrl1_q[0]),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_pop(tx_pop),
  .wr_data(wr_data), .imask(imask_q), .irq(irq_o)
);

// File: tb/spi_port_ctrl_test.sv
`timescale 1ns/100ps
module spi_port_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        xchg_req_o, xchg_ack_i = 1'b0, irq_o;
  logic [15:0] xchg_wdata_o, xchg_rdata_i = '0;

  int n_run = 0, n_fail = 0;
  int req_cnt = 0, lat = 0;
  logic req_prev = 1'b0;
  logic [15:0] last_sent = '0;

  always #2.5 clk_i = ~clk_i;

  spi_port_ctrl uut (.*);

  // external shifter: acks after 2 cycles, returns sent ^ 16'hA5A5
  always @(negedge clk_i) begin
    if (xchg_req_o && !req_prev) req_cnt++;
    req_prev = xchg_req_o;
    if (xchg_ack_i) begin
      xchg_ack_i = 1'b0;
    end else if (xchg_req_o) begin
      if (lat == 2) begin
        lat = 0;
        last_sent = xchg_wdata_o;
        xchg_rdata_i = xchg_wdata_o ^ 16'hA5A5;
        xchg_ack_i = 1'b1;
      end else lat++;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [15:0] exp_stat(input int tx, input int rx);
    exp_stat = 16'((tx == 0) | ((tx != 8) << 1) | ((rx != 0) << 2) | ((rx == 8) << 3) | ((tx != 0) << 4));
  endfunction

  function automatic logic [15:0] exp_raw(input int tx, input int rx);
    exp_raw = 16'(((rx >= 4) << 2) | ((tx <= 4) << 3));
  endfunction

  function automatic logic [15:0] word(input int k);
    word = 16'(k * 16'h1357 + 16'h00F1);
  endfunction

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [15:0] ids [8];
    int base;
    ids = '{16'h22, 16'h10, 16'h04, 16'h00, 16'h0D, 16'hF0, 16'h05, 16'hB1};
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R1 reset state
    rd(12'h00C, d); check("R1 status", d, 16'h0003);
    rd(12'h018, d); check("R1 raw", d, 16'h0008);
    rd(12'h01C, d); check("R1 masked", d, 16'h0000);
    check("R1 irq", {15'b0, irq_o}, 16'h0000);
    rd(12'h008, d); check("R1 data", d, 16'h0000);

    // R5 frame size sweep in loopback
    wr(12'h004, 16'h0003);
    for (int fs = 0; fs < 16; fs++) begin
      wr(12'h000, 16'(fs));
      wr(12'h008, 16'hBEEF ^ 16'(fs));
      rd(12'h008, d);
      check("R5 frame mask", d, (16'hBEEF ^ 16'(fs)) & 16'((32'd1 << (fs + 1)) - 1));
    end
    // R5 receive-side cut: queue at 16 bits, shrink frame before transfer
    wr(12'h004, 16'h0000);
    wr(12'h000, 16'h000F);
    wr(12'h008, 16'h9ABC);
    wr(12'h000, 16'h0003);
    wr(12'h004, 16'h0003);
    idle(2);
    rd(12'h008, d); check("R5 rx cut", d, 16'h000C);

    // R2 R3 R10 transmit occupancy sweep, port disabled (R9)
    wr(12'h004, 16'h0001);
    wr(12'h000, 16'h000F);
    for (int n = 0; n <= 8; n++) begin
      rd(12'h00C, d); check("R2 tx status", d, exp_stat(n, 0));
      rd(12'h018, d); check("R10 tx raw", d, exp_raw(n, 0));
      if (n < 8) wr(12'h008, word(n));
    end
    wr(12'h008, 16'hDEAD);
    rd(12'h00C, d); check("R3 drop status", d, exp_stat(8, 0));
    idle(4);
    rd(12'h00C, d); check("R9 held", d, exp_stat(8, 0));
    wr(12'h004, 16'h0003);
    idle(12);
    for (int r = 8; r >= 1; r--) begin
      rd(12'h00C, d); check("R2 rx status", d, exp_stat(0, r));
      rd(12'h018, d); check("R10 rx raw", d, exp_raw(0, r));
      rd(12'h008, d); check("R6 R3 order", d, word(8 - r));
    end
    rd(12'h008, d); check("R4 empty read", d, 16'h0000);
    rd(12'h00C, d); check("R4 status", d, exp_stat(0, 0));

    // R8 stall with receive FIFO full
    for (int k = 0; k < 8; k++) wr(12'h008, word(20 + k));
    idle(12);
    for (int k = 0; k < 3; k++) wr(12'h008, word(28 + k));
    idle(6);
    rd(12'h00C, d); check("R8 stalled", d, exp_stat(3, 8));
    for (int k = 0; k < 11; k++) begin
      rd(12'h008, d); check("R8 release order", d, word(20 + k));
    end
    rd(12'h00C, d); check("R8 drained", d, exp_stat(0, 0));
    check("R6 no request in loopback", 16'(req_cnt), 16'd0);

    // R7 handshake mode with 8-bit frames
    wr(12'h004, 16'h0000);
    wr(12'h000, 16'h0007);
    wr(12'h004, 16'h0002);
    for (int k = 0; k < 5; k++) wr(12'h008, word(40 + k));
    idle(30);
    check("R7 one request per word", 16'(req_cnt), 16'd5);
    check("R7 last word sent", last_sent, word(44) & 16'h00FF);
    for (int k = 0; k < 5; k++) begin
      rd(12'h008, d);
      check("R7 returned word", d, ((word(40 + k) & 16'h00FF) ^ 16'hA5A5) & 16'h00FF);
    end

    // R11 R10 interrupts
    wr(12'h004, 16'h0003);
    wr(12'h000, 16'h000F);
    wr(12'h014, 16'h0008);
    check("R11 tx irq", {15'b0, irq_o}, 16'h0001);
    rd(12'h01C, d); check("R11 masked tx", d, 16'h0008);
    wr(12'h014, 16'h0004);
    check("R11 rx irq low", {15'b0, irq_o}, 16'h0000);
    for (int k = 0; k < 4; k++) wr(12'h008, word(60 + k));
    idle(2);
    check("R11 rx irq high", {15'b0, irq_o}, 16'h0001);
    rd(12'h01C, d); check("R11 masked rx", d, 16'h0004);
    wr(12'h020, 16'h000F);
    rd(12'h018, d); check("R10 clear no effect", d, 16'h000C);
    rd(12'h014, d); check("R11 mask readback", d, 16'h0004);
    wr(12'h014, 16'h0000);
    check("R11 masked off", {15'b0, irq_o}, 16'h0000);
    for (int k = 0; k < 4; k++) rd(12'h008, d);

    // R12 register readback, DMA, unmapped
    wr(12'h004, 16'h0000);
    wr(12'h000, 16'hA5C7);
    rd(12'h000, d); check("R12 ctrl0", d, 16'hA5C7);
    wr(12'h004, 16'hFFF0);
    rd(12'h004, d); check("R12 ctrl1", d, 16'h0000);
    wr(12'h010, 16'h1234);
    rd(12'h010, d); check("R12 prescale", d, 16'h0034);
    wr(12'h024, 16'h0003);
    rd(12'h024, d); check("R12 dma", d, 16'h0000);
    wr(12'h030, 16'hFFFF);
    rd(12'h030, d); check("R12 unmapped read", d, 16'h0000);
    rd(12'h000, d); check("R12 unmapped write", d, 16'hA5C7);
    rd(12'h00C, d); check("R12 status intact", d, 16'h0003);

    // R13 identification bytes
    for (int i = 0; i < 8; i++) begin
      base = 12'hFE0 + i * 4;
      rd(12'(base), d); check("R13 id", d, ids[i]);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule